// File: doc/BRIEF.md
# SDRAM Read Cycle Sequencer

This block runs read transactions against one bank of a 16-bit SDRAM whose row address, column address and read data all share a single bidirectional bus. The host presents a request with a row, a column and a transfer kind. A fixed read returns one or two halfwords. A streaming read keeps returning halfwords until the host raises a stop line. The block produces the memory command pins, the byte masks, the outgoing bus value with its output enable, and a registered halfword with a valid strobe for each capture.

Each transaction opens a row, waits one clock, and issues the read with the column on the bus. It then releases the bus for one turnaround clock and captures one halfword per clock. A streaming read is closed with a Burst Terminate command. Every transaction ends with a deselected clock, so consecutive transactions never touch. The memory is assumed to be already set to a CAS latency of two. Refresh, writes and initialisation belong elsewhere.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, busy is 0, the memory is deselected (command pins 1111), the byte masks are 11, the bus output enable is 0 and rd_valid is 0.
- R2: A request is accepted only in a cycle where busy is 0. A request presented while busy is 1 starts no transaction. Busy goes to 1 in the cycle after acceptance.
- R3: The cycle after acceptance issues Activate, encoded {sel_n, row_strb_n, col_strb_n, wr_en_n} = 0011, with the accepted row on the bus, output enable 1 and byte masks 11.
- R4: The cycle after Activate is a NOP (0111) with the bus still driven. The next cycle is Read (0101) with the accepted column on the bus, output enable 1 and byte masks 00.
- R5: The cycle after Read is a NOP with the bus output enable 0 and byte masks 00. No data is captured in that cycle.
- R6: Data cycles follow the turnaround. They are NOPs with output enable 0 and byte masks 00. The bus_in value present in each data cycle appears on rd_data with rd_valid 1 in the next cycle. A fixed read has exactly 1 data cycle when req_two is 0 and exactly 2 when it is 1.
- R7: After the last data cycle, or after Burst Terminate, there is exactly one cycle with busy 1, the memory deselected and the byte masks 11. Busy then falls. Any two Activates are therefore separated by at least one deselected clock.
- R8: In a streaming read (req_stream 1), data cycles continue until stop is 1 in a data cycle. That cycle's halfword is the last one captured. The next cycle is Burst Terminate (0110) with byte masks 11 and output enable 0.
- R9: The clock-enable pin is 1 in every cycle.
- R10: The stop input has no effect during a fixed read or outside the data cycles of a streaming read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_row | input | 16 | Row address of the request |
| req_col | input | 16 | Column address of the request |
| req_two | input | 1 | Fixed read length: 0 gives one halfword, 1 gives two |
| req_stream | input | 1 | 1 selects a streaming read ended by stop |
| stop | input | 1 | Ends a streaming read in the current data cycle |
| busy | output | 1 | Transaction in progress, including the trailing idle clock |
| mem_clk_en | output | 1 | Memory clock enable |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_row_strb_n | output | 1 | Row strobe, active low |
| mem_col_strb_n | output | 1 | Column strobe, active low |
| mem_wr_en_n | output | 1 | Write enable, active low |
| mem_byte_mask | output | 2 | Byte masks, upper lane in bit 1 |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_oe | output | 1 | Shared bus output enable |
| bus_in | input | 16 | Value read from the shared bus |
| rd_data | output | 16 | Captured halfword |
| rd_valid | output | 1 | rd_data holds a new halfword |

## Verification
The bench goes after the turnaround clock. A design that keeps the bus enabled one cycle too long would fight the memory's first halfword, and one that captures in that cycle would deliver a stray word. It checks that the data count matches req_two exactly, since an off-by-one counter shows up as a missing or an extra rd_valid. Streaming reads of one and of several halfwords check that the stop cycle is the last capture and is followed by Burst Terminate. A sequencer that also sampled stop outside data cycles would end reads early. A request held high through a whole transaction probes acceptance: a design that ignored busy would restart mid-transaction or skip the deselected clock.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_WAIT,
        ST_READ,
        ST_TURN,
        ST_DATA,
        ST_TERM,
        ST_REST
    } seq_state_e;

    typedef struct packed {
        logic sel_n;
        logic row_n;
        logic col_n;
        logic wr_n;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_OPEN   = 4'b0011;
    localparam mem_cmd_t CMD_READ   = 4'b0101;
    localparam mem_cmd_t CMD_TERM   = 4'b0110;
    localparam mem_cmd_t CMD_NOP    = 4'b0111;
    localparam mem_cmd_t CMD_DESEL  = 4'b1111;

    function automatic mem_cmd_t cmd_for(seq_state_e s);
        case (s)
            ST_OPEN:                  return CMD_OPEN;
            ST_READ:                  return CMD_READ;
            ST_TERM:                  return CMD_TERM;
            ST_WAIT, ST_TURN, ST_DATA: return CMD_NOP;
            default:                  return CMD_DESEL;
        endcase
    endfunction

    function automatic logic lanes_enabled(seq_state_e s);
        return (s == ST_READ) || (s == ST_TURN) || (s == ST_DATA);
    endfunction

endpackage

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
    import sdram_rd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int MAX_N = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [DW-1:0] req_row,
    input  logic [DW-1:0] req_col,
    input  logic          req_two,
    input  logic          req_stream,
    input  logic          stop,
    output seq_state_e    state,
    output logic [DW-1:0] row_q,
    output logic [DW-1:0] col_q
);
    localparam int CNT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    logic [CNT_W-1:0] remain;
    logic             stream_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            remain   <= '0;
            stream_q <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    row_q    <= req_row;
                    col_q    <= req_col;
                    stream_q <= req_stream;
                    remain   <= CNT_W'(req_two);
                    state    <= ST_OPEN;
                end
                ST_OPEN: state <= ST_WAIT;
                ST_WAIT: state <= ST_READ;
                ST_READ: state <= ST_TURN;
                ST_TURN: state <= ST_DATA;
                ST_DATA: begin
                    if (stream_q) begin
                        if (stop) state <= ST_TERM;
                    end else if (remain == '0) begin
                        state <= ST_REST;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                ST_TERM: state <= ST_REST;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_rd_drive.sv
module sdram_rd_drive
    import sdram_rd_pkg::*;
#(
    parameter int DW = 16
) (
    input  seq_state_e    state,
    input  logic [DW-1:0] row_q,
    input  logic [DW-1:0] col_q,
    output logic          busy,
    output logic          mem_clk_en,
    output mem_cmd_t      cmd,
    output logic [DW/8-1:0] mask,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);
    localparam int LANES = DW / 8;

    logic lane_on;

    always_comb begin
        busy       = (state != ST_IDLE);
        mem_clk_en = 1'b1;
        cmd        = cmd_for(state);
        lane_on    = lanes_enabled(state);
        bus_oe     = (state == ST_OPEN) || (state == ST_WAIT) || (state == ST_READ);
        bus_out    = (state == ST_READ) ? col_q : row_q;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g] = ~lane_on;
    end

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
    import sdram_rd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_e    state,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_DATA);
            if (state == ST_DATA) rd_data <= bus_in;
        end
    end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdram_rd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int MAX_N = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [DW-1:0] req_row,
    input  logic [DW-1:0] req_col,
    input  logic          req_two,
    input  logic          req_stream,
    input  logic          stop,
    output logic          busy,
    output logic          mem_clk_en,
    output logic          mem_sel_n,
    output logic          mem_row_strb_n,
    output logic          mem_col_strb_n,
    output logic          mem_wr_en_n,
    output logic [DW/8-1:0] mem_byte_mask,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    seq_state_e    state;
    logic [DW-1:0] row_q;
    logic [DW-1:0] col_q;
    mem_cmd_t      cmd;

    sdram_rd_ctrl #(.DW(DW), .MAX_N(MAX_N)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_two    (req_two),
        .req_stream (req_stream),
        .stop       (stop),
        .state      (state),
        .row_q      (row_q),
        .col_q      (col_q)
    );

    sdram_rd_drive #(.DW(DW)) u_drive (
        .state      (state),
        .row_q      (row_q),
        .col_q      (col_q),
        .busy       (busy),
        .mem_clk_en (mem_clk_en),
        .cmd        (cmd),
        .mask       (mem_byte_mask),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe)
    );

    sdram_rd_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .bus_in   (bus_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign mem_sel_n      = cmd.sel_n;
    assign mem_row_strb_n = cmd.row_n;
    assign mem_col_strb_n = cmd.col_n;
    assign mem_wr_en_n    = cmd.wr_n;

endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [DW-1:0]   req_row,
    input logic            busy,
    input logic            mem_clk_en,
    input logic            mem_sel_n,
    input logic            mem_row_strb_n,
    input logic            mem_col_strb_n,
    input logic            mem_wr_en_n,
    input logic [DW/8-1:0] mem_byte_mask,
    input logic [DW-1:0]   bus_out,
    input logic            bus_oe,
    input logic            rd_valid
);
    logic [3:0] c;
    assign c = {mem_sel_n, mem_row_strb_n, mem_col_strb_n, mem_wr_en_n};

    assert_open_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0011) |=> (c == 4'b0111) ##1 (c == 4'b0101));

    assert_row_driven_R3: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0011) |-> (bus_oe && bus_out == $past(req_row)));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0101) |=> (!bus_oe && mem_byte_mask == '0 && !rd_valid));

    assert_capture_window_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(c == 4'b0111 && !bus_oe && mem_byte_mask == '0));

    assert_idle_before_open_R7: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0011) |-> $past(mem_sel_n));

    assert_term_then_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0110) |=> (mem_sel_n && busy));

    assert_clk_en_R9: assert property (@(posedge clk) disable iff (rst)
        mem_clk_en);

    assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> (c != 4'b0011));

endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_row        (req_row),
    .busy           (busy),
    .mem_clk_en     (mem_clk_en),
    .mem_sel_n      (mem_sel_n),
    .mem_row_strb_n (mem_row_strb_n),
    .mem_col_strb_n (mem_col_strb_n),
    .mem_wr_en_n    (mem_wr_en_n),
    .mem_byte_mask  (mem_byte_mask),
    .bus_out        (bus_out),
    .bus_oe         (bus_oe),
    .rd_valid       (rd_valid)
);

// File: tb/sdram_rd_seq_bench.sv
`timescale 1ns/1ps
module sdram_rd_seq_bench;
    localparam int K_IDLE = 0, K_OPEN = 1, K_WAIT = 2, K_READ = 3,
                   K_TURN = 4, K_DATA = 5, K_TERM = 6, K_REST = 7;

    typedef struct {
        int          kind;
        bit          strm;
        bit          last;
        logic [15:0] bus;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic        req_two = 1'b0;
    logic        req_stream = 1'b0;
    logic        stop = 1'b0;
    logic [15:0] bus_in = '0;
    logic        busy, mem_clk_en, mem_sel_n, mem_row_strb_n, mem_col_strb_n, mem_wr_en_n;
    logic [1:0]  mem_byte_mask;
    logic [15:0] bus_out, rd_data;
    logic        bus_oe, rd_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    rec_t q[$];
    rec_t cur;
    bit exp_v = 0;
    logic [15:0] exp_d = '0;
    logic [15:0] pat = 16'h5a3c;
    string scen = "R6";

    always #2 clk = ~clk;

    sdram_rd_seq u_sdram_rd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_row(req_row),
        .req_col(req_col), .req_two(req_two), .req_stream(req_stream), .stop(stop),
        .busy(busy), .mem_clk_en(mem_clk_en), .mem_sel_n(mem_sel_n),
        .mem_row_strb_n(mem_row_strb_n), .mem_col_strb_n(mem_col_strb_n),
        .mem_wr_en_n(mem_wr_en_n), .mem_byte_mask(mem_byte_mask), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic string tag_of(int k);
        case (k)
            K_OPEN:          return "R3";
            K_WAIT, K_READ:  return "R4";
            K_TURN:          return "R5";
            K_DATA:          return "R6";
            K_TERM:          return "R8";
            K_REST:          return "R7";
            default:         return "R2";
        endcase
    endfunction

    task automatic compare();
        logic [3:0] ec;
        logic [1:0] em;
        bit eo, eb, ok;
        case (cur.kind)
            K_OPEN: begin ec = 4'b0011; em = 2'b11; eo = 1; eb = 1; end
            K_WAIT: begin ec = 4'b0111; em = 2'b11; eo = 1; eb = 1; end
            K_READ: begin ec = 4'b0101; em = 2'b00; eo = 1; eb = 1; end
            K_TURN, K_DATA: begin ec = 4'b0111; em = 2'b00; eo = 0; eb = 1; end
            K_TERM: begin ec = 4'b0110; em = 2'b11; eo = 0; eb = 1; end
            K_REST: begin ec = 4'b1111; em = 2'b11; eo = 0; eb = 1; end
            default: begin ec = 4'b1111; em = 2'b11; eo = 0; eb = 0; end
        endcase
        // R9: clock enable checked in every cycle
        ok = mem_clk_en === 1'b1
          && {mem_sel_n, mem_row_strb_n, mem_col_strb_n, mem_wr_en_n} === ec
          && mem_byte_mask === em && bus_oe === eo && busy === eb
          && (!(cur.kind == K_OPEN || cur.kind == K_READ) || bus_out === cur.bus)
          && rd_valid === exp_v && (!exp_v || rd_data === exp_d);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s/%s/R9 kind=%0d: act cke=%b cmd=%b m=%b oe=%b busy=%b bus=%h v=%b d=%h exp cmd=%b m=%b oe=%b busy=%b bus=%h v=%b d=%h",
                tag_of(cur.kind), scen, cur.kind, mem_clk_en,
                {mem_sel_n, mem_row_strb_n, mem_col_strb_n, mem_wr_en_n}, mem_byte_mask,
                bus_oe, busy, bus_out, rd_valid, rd_data, ec, em, eo, eb, cur.bus, exp_v, exp_d);
        end
    endtask

    task automatic push(int k, bit s, bit l, logic [15:0] b);
        rec_t r;
        r.kind = k; r.strm = s; r.last = l; r.bus = b;
        q.push_back(r);
    endtask

    task automatic cycle(bit rv, logic [15:0] row, logic [15:0] col,
                         bit two, bit strm, int nlen, bit noise);
        req_valid = rv; req_row = row; req_col = col; req_two = two; req_stream = strm;
        if (cur.kind == K_DATA) stop = cur.strm ? cur.last : noise;
        else stop = noise;
        pat = {pat[14:0], pat[15] ^ pat[13]} + 16'h0b1d;
        bus_in = pat;
        exp_v = (cur.kind == K_DATA);
        exp_d = pat;
        if (cur.kind == K_IDLE && rv) begin
            push(K_OPEN, 0, 0, row);
            push(K_WAIT, 0, 0, 16'h0);
            push(K_READ, 0, 0, col);
            push(K_TURN, 0, 0, 16'h0);
            if (strm) begin
                for (int i = 0; i < nlen; i++) push(K_DATA, 1, i == nlen - 1, 16'h0);
                push(K_TERM, 0, 0, 16'h0);
            end else begin
                for (int i = 0; i < (two ? 2 : 1); i++) push(K_DATA, 0, 0, 16'h0);
            end
            push(K_REST, 0, 0, 16'h0);
        end
        @(posedge clk);
        @(negedge clk);
        if (q.size() > 0) cur = q.pop_front();
        else begin cur.kind = K_IDLE; cur.strm = 0; cur.last = 0; cur.bus = 0; end
        compare();
    endtask

    task automatic drain(bit noise);
        while (q.size() > 0 || cur.kind != K_IDLE) cycle(0, 16'h0, 16'h0, 0, 0, 0, noise);
        cycle(0, 16'h0, 16'h0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cur.kind = K_IDLE; cur.strm = 0; cur.last = 0; cur.bus = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compared++;
        if (!(busy === 1'b0 && {mem_sel_n, mem_row_strb_n, mem_col_strb_n, mem_wr_en_n} === 4'b1111
              && mem_byte_mask === 2'b11 && bus_oe === 1'b0 && rd_valid === 1'b0)) begin
            mismatched++;
            $display("FAIL R1: act busy=%b sel=%b m=%b oe=%b v=%b exp 0 1 11 0 0",
                     busy, mem_sel_n, mem_byte_mask, bus_oe, rd_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        compare();
        cycle(0, 16'h0, 16'h0, 0, 0, 0, 0);

        scen = "R6"; // fixed single halfword
        cycle(1, 16'h1234, 16'h00a7, 0, 0, 0, 0);
        drain(0);
        scen = "R6"; // fixed two halfwords
        cycle(1, 16'hbeef, 16'h0301, 1, 0, 0, 0);
        drain(0);
        scen = "R10"; // stop held high through a fixed read
        cycle(1, 16'h0f0f, 16'h0055, 1, 0, 0, 1);
        drain(1);
        scen = "R2"; // request held high across busy
        for (int i = 0; i < 20; i++) cycle(1, 16'h7e01, 16'h0123, 1, 0, 0, 0);
        drain(0);
        scen = "R8"; // stream of one
        cycle(1, 16'h2222, 16'h0010, 0, 1, 1, 0);
        drain(0);
        scen = "R8"; // stream of five
        cycle(1, 16'h3333, 16'h0020, 0, 1, 5, 0);
        drain(0);
        scen = "R10"; // stream with stop high before data cycles
        cycle(1, 16'h4444, 16'h0030, 1, 1, 3, 1);
        for (int i = 0; i < 4; i++) cycle(0, 16'h0, 16'h0, 0, 0, 0, 1);
        drain(0);
        scen = "R7"; // back-to-back requests on mixed kinds
        cycle(1, 16'h5555, 16'h0040, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) cycle(1, 16'h6666, 16'h0050, 0, 1, 2, 0);
        drain(0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule